// File: doc/BRIEF.md
# Averaged Integral Image Engine

This block takes a raster stream of pixels and, for every pixel, produces two running statistics over the rectangle that reaches from the top-left corner of the frame to that pixel, both corners included. The first is the mean of the pixel values in that rectangle. The second is the mean of their squares. Because each mean is a sum divided by the rectangle's area, it never leaves the range of a single pixel (or a single squared pixel), however large the rectangle grows.

The engine counts the column and row of each incoming pixel. It multiplies each mean by the column number times the row number to give a rescaled sum and a rescaled sum of squares. Feature extractors further down the chain use these values. Internally it keeps exact sums: a running sum for the current row and a line buffer that holds the previous row's integral. The means come from those exact sums by truncating division.

A pixel may carry a start-of-frame flag that forces it to position (1,1). Otherwise, positions advance in raster order and wrap at the end of the frame. Results leave the block in input order with a fixed latency, and each carries its coordinates.

Top module: `aii_engine`

## Requirements
- R1: While `rst_n` is low, `out_valid` is low. Results still in flight when reset is asserted are dropped. The first pixel accepted after reset is at x=1, y=1.
- R2: Accepted pixels get 1-based coordinates in raster order. x runs from 1 to IMG_W, then y increments. After (IMG_W, IMG_H) the next pixel is at (1,1). Each result carries its pixel's coordinates on `out_x` and `out_y`.
- R3: `out_avg` equals the sum of all pixels with column ≤ x and row ≤ y in the current frame, divided by x·y and truncated toward zero.
- R4: `out_avg_sq` equals the same sum taken over squared pixel values, divided by x·y and truncated toward zero. It is never smaller than `out_avg` squared.
- R5: `out_sum` equals `out_avg`·x·y. When the exact sum is divisible by x·y, `out_sum` equals that exact sum.
- R6: `out_sum_sq` equals `out_avg_sq`·x·y. When the exact sum of squares is divisible by x·y, `out_sum_sq` equals it.
- R7: A pixel presented with `pix_valid` high before rising edge E produces exactly one result, visible with `out_valid` high after edge E+2. Cycles with `pix_valid` low produce no result and do not advance the position.
- R8: A pixel with `pix_sof` high and `pix_valid` high is placed at (1,1) wherever the count stood. No pixel from before it contributes to any later result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_valid | input | 1 | Pixel present this cycle |
| pix_sof | input | 1 | Pixel starts a new frame at (1,1) |
| pix_data | input | PIX_W | Pixel value, unsigned |
| out_valid | output | 1 | Result present this cycle |
| out_x | output | clog2(IMG_W+1) | Column of the result, 1-based |
| out_y | output | clog2(IMG_H+1) | Row of the result, 1-based |
| out_avg | output | PIX_W | Truncated mean of the pixels |
| out_avg_sq | output | 2·PIX_W | Truncated mean of the squared pixels |
| out_sum | output | PIX_W+clog2(IMG_W+1)+clog2(IMG_H+1) | Mean times x·y |
| out_sum_sq | output | 2·PIX_W+clog2(IMG_W+1)+clog2(IMG_H+1) | Squared mean times x·y |

## Verification
The bench runs frames with extreme values (0 and full scale) next to each other. A divider that loses a remainder bit, or a rescale that uses the wrong coordinate, then shows up as a wrong mean or a wrong product. Back-to-back frames check the wrap from the last pixel to (1,1). If the line buffer were not ignored on the first row, stale rows would leak into the new frame's sums. A start-of-frame pulse in mid-row tests the same leak, and a design that only reset the column would report a wrong y. Idle gaps and a reset applied while results are in flight check that the pipeline neither repeats, drops nor shifts results, and that it restarts at (1,1).

// File: rtl/aii_pkg.sv
package aii_pkg;
  localparam int DEF_PIX_W = 8;
  localparam int DEF_IMG_W = 320;
  localparam int DEF_IMG_H = 240;

  // bits needed to hold the values 0..n
  function automatic int span_bits(input int n);
    return $clog2(n + 1);
  endfunction

  // bits needed to index 0..n-1
  function automatic int idx_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/aii_accum.sv
module aii_accum
  import aii_pkg::*;
#(
  parameter int PIX_W = DEF_PIX_W,
  parameter int IMG_W = DEF_IMG_W,
  parameter int IMG_H = DEF_IMG_H
) (
  input  logic                                         clk,
  input  logic                                         rst_n,
  input  logic                                         in_valid,
  input  logic                                         in_sof,
  input  logic [PIX_W-1:0]                             in_pix,
  output logic                                         acc_valid,
  output logic [span_bits(IMG_W)-1:0]                  acc_x,
  output logic [span_bits(IMG_H)-1:0]                  acc_y,
  output logic [span_bits(IMG_W)+span_bits(IMG_H)-1:0] acc_area,
  output logic [PIX_W+span_bits(IMG_W)+span_bits(IMG_H)-1:0]   acc_sum,
  output logic [2*PIX_W+span_bits(IMG_W)+span_bits(IMG_H)-1:0] acc_sq
);
  localparam int XW       = span_bits(IMG_W);
  localparam int YW       = span_bits(IMG_H);
  localparam int CW       = idx_bits(IMG_W);
  localparam int RW       = idx_bits(IMG_H);
  localparam int AREA_W   = XW + YW;
  localparam int SQ_W     = 2 * PIX_W;
  localparam int SUM_W    = PIX_W + AREA_W;
  localparam int SQSUM_W  = SQ_W + AREA_W;
  localparam int ROWSUM_W = PIX_W + XW;
  localparam int ROWSQ_W  = SQ_W + XW;

  logic [CW-1:0]       col_q, col_n, cur_col;
  logic [RW-1:0]       row_q, row_n, cur_row;
  logic [ROWSUM_W-1:0] rsum_q, rsum_n;
  logic [ROWSQ_W-1:0]  rsq_q, rsq_n;
  logic [SQ_W-1:0]     pix_sq;
  logic [SUM_W-1:0]    above_sum, ii_n;
  logic [SQSUM_W-1:0]  above_sq, iisq_n;
  logic [XW-1:0]       x_n;
  logic [YW-1:0]       y_n;
  logic [AREA_W-1:0]   area_n;
  logic                last_col;

  // previous-row integral, one entry per column
  logic [SUM_W-1:0]    lb_sum [IMG_W];
  logic [SQSUM_W-1:0]  lb_sq  [IMG_W];

  always_comb begin
    cur_col   = in_sof ? '0 : col_q;
    cur_row   = in_sof ? '0 : row_q;
    pix_sq    = SQ_W'(in_pix) * SQ_W'(in_pix);
    rsum_n    = ((cur_col == '0) ? '0 : rsum_q) + ROWSUM_W'(in_pix);
    rsq_n     = ((cur_col == '0) ? '0 : rsq_q) + ROWSQ_W'(pix_sq);
    above_sum = (cur_row == '0) ? '0 : lb_sum[cur_col];
    above_sq  = (cur_row == '0) ? '0 : lb_sq[cur_col];
    ii_n      = above_sum + SUM_W'(rsum_n);
    iisq_n    = above_sq + SQSUM_W'(rsq_n);
    x_n       = XW'(cur_col) + XW'(1);
    y_n       = YW'(cur_row) + YW'(1);
    area_n    = AREA_W'(x_n) * AREA_W'(y_n);
    last_col  = (cur_col == CW'(IMG_W - 1));
    col_n     = last_col ? '0 : cur_col + CW'(1);
    if (last_col) begin
      row_n = (cur_row == RW'(IMG_H - 1)) ? '0 : cur_row + RW'(1);
    end else begin
      row_n = cur_row;
    end
  end

  // control state with reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q     <= '0;
      row_q     <= '0;
      rsum_q    <= '0;
      rsq_q     <= '0;
      acc_valid <= 1'b0;
    end else begin
      acc_valid <= in_valid;
      if (in_valid) begin
        col_q  <= col_n;
        row_q  <= row_n;
        rsum_q <= rsum_n;
        rsq_q  <= rsq_n;
      end
    end
  end

  // datapath and line buffer, no reset
  always_ff @(posedge clk) begin
    if (in_valid) begin
      acc_x            <= x_n;
      acc_y            <= y_n;
      acc_area         <= area_n;
      acc_sum          <= ii_n;
      acc_sq           <= iisq_n;
      lb_sum[cur_col]  <= ii_n;
      lb_sq[cur_col]   <= iisq_n;
    end
  end
endmodule

// File: rtl/aii_div.sv
module aii_div #(
  parameter int NUM_W = 25,
  parameter int DEN_W = 17,
  parameter int QUO_W = 8
) (
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic [QUO_W-1:0] quo
);
  localparam int CMP_W = ((NUM_W > DEN_W) ? NUM_W : DEN_W) + QUO_W;

  // partial remainders; rem[g] is what is left after quotient bit g
  logic [CMP_W-1:0] rem [1:QUO_W];

  assign rem[QUO_W] = CMP_W'(num);

  for (genvar g = QUO_W - 1; g >= 0; g--) begin : g_stage
    logic [CMP_W-1:0] shf;
    assign shf    = CMP_W'(den) << g;
    assign quo[g] = (rem[g+1] >= shf);
    if (g > 0) begin : g_rem
      assign rem[g] = quo[g] ? (rem[g+1] - shf) : rem[g+1];
    end
  end
endmodule

// File: rtl/aii_engine.sv
module aii_engine
  import aii_pkg::*;
#(
  parameter int PIX_W = DEF_PIX_W,
  parameter int IMG_W = DEF_IMG_W,
  parameter int IMG_H = DEF_IMG_H
) (
  input  logic                                                 clk,
  input  logic                                                 rst_n,
  input  logic                                                 pix_valid,
  input  logic                                                 pix_sof,
  input  logic [PIX_W-1:0]                                     pix_data,
  output logic                                                 out_valid,
  output logic [span_bits(IMG_W)-1:0]                          out_x,
  output logic [span_bits(IMG_H)-1:0]                          out_y,
  output logic [PIX_W-1:0]                                     out_avg,
  output logic [2*PIX_W-1:0]                                   out_avg_sq,
  output logic [PIX_W+span_bits(IMG_W)+span_bits(IMG_H)-1:0]   out_sum,
  output logic [2*PIX_W+span_bits(IMG_W)+span_bits(IMG_H)-1:0] out_sum_sq
);
  localparam int XW      = span_bits(IMG_W);
  localparam int YW      = span_bits(IMG_H);
  localparam int AREA_W  = XW + YW;
  localparam int SQ_W    = 2 * PIX_W;
  localparam int SUM_W   = PIX_W + AREA_W;
  localparam int SQSUM_W = SQ_W + AREA_W;

  // stage 1: exact sums
  logic               s1_valid;
  logic [XW-1:0]      s1_x;
  logic [YW-1:0]      s1_y;
  logic [AREA_W-1:0]  s1_area;
  logic [SUM_W-1:0]   s1_sum;
  logic [SQSUM_W-1:0] s1_sq;

  aii_accum #(.PIX_W(PIX_W), .IMG_W(IMG_W), .IMG_H(IMG_H)) u_accum (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (pix_valid),
    .in_sof    (pix_sof),
    .in_pix    (pix_data),
    .acc_valid (s1_valid),
    .acc_x     (s1_x),
    .acc_y     (s1_y),
    .acc_area  (s1_area),
    .acc_sum   (s1_sum),
    .acc_sq    (s1_sq)
  );

  // stage 2: truncating division by the area
  logic [PIX_W-1:0]   avg_n;
  logic [SQ_W-1:0]    avgsq_n;

  aii_div #(.NUM_W(SUM_W), .DEN_W(AREA_W), .QUO_W(PIX_W)) u_div_pix (
    .num (s1_sum),
    .den (s1_area),
    .quo (avg_n)
  );

  aii_div #(.NUM_W(SQSUM_W), .DEN_W(AREA_W), .QUO_W(SQ_W)) u_div_sq (
    .num (s1_sq),
    .den (s1_area),
    .quo (avgsq_n)
  );

  logic               s2_valid;
  logic [XW-1:0]      s2_x;
  logic [YW-1:0]      s2_y;
  logic [AREA_W-1:0]  s2_area;
  logic [PIX_W-1:0]   s2_avg;
  logic [SQ_W-1:0]    s2_avgsq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_valid <= 1'b0;
    end else begin
      s2_valid <= s1_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (s1_valid) begin
      s2_x     <= s1_x;
      s2_y     <= s1_y;
      s2_area  <= s1_area;
      s2_avg   <= avg_n;
      s2_avgsq <= avgsq_n;
    end
  end

  // stage 3: rescale the means back to sums
  logic [SUM_W-1:0]   sum_n;
  logic [SQSUM_W-1:0] sumsq_n;

  always_comb begin
    sum_n   = SUM_W'(s2_avg) * SUM_W'(s2_area);
    sumsq_n = SQSUM_W'(s2_avgsq) * SQSUM_W'(s2_area);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else begin
      out_valid <= s2_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (s2_valid) begin
      out_x      <= s2_x;
      out_y      <= s2_y;
      out_avg    <= s2_avg;
      out_avg_sq <= s2_avgsq;
      out_sum    <= sum_n;
      out_sum_sq <= sumsq_n;
    end
  end
endmodule

// File: rtl/aii_engine_chk.sv
module aii_engine_chk
  import aii_pkg::*;
#(
  parameter int PIX_W = DEF_PIX_W,
  parameter int IMG_W = DEF_IMG_W,
  parameter int IMG_H = DEF_IMG_H
) (
  input logic                                               clk,
  input logic                                               rst_n,
  input logic                                               pix_valid,
  input logic                                               out_valid,
  input logic [span_bits(IMG_W)-1:0]                        out_x,
  input logic [span_bits(IMG_H)-1:0]                        out_y,
  input logic [PIX_W-1:0]                                   out_avg,
  input logic [2*PIX_W-1:0]                                 out_avg_sq,
  input logic [PIX_W+span_bits(IMG_W)+span_bits(IMG_H)-1:0] out_sum
);
  localparam int XW    = span_bits(IMG_W);
  localparam int YW    = span_bits(IMG_H);
  localparam int SQ_W  = 2 * PIX_W;
  localparam int SUM_W = PIX_W + XW + YW;

  logic          pv1, pv2, pv3;
  logic          have_prev;
  logic [XW-1:0] prev_x;
  logic [YW-1:0] prev_y;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pv1       <= 1'b0;
      pv2       <= 1'b0;
      pv3       <= 1'b0;
      have_prev <= 1'b0;
      prev_x    <= '0;
      prev_y    <= '0;
    end else begin
      pv1 <= pix_valid;
      pv2 <= pv1;
      pv3 <= pv2;
      if (out_valid) begin
        have_prev <= 1'b1;
        prev_x    <= out_x;
        prev_y    <= out_y;
      end
    end
  end

  AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == pv3);  // R7

  AST_COORD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_x >= XW'(1) && out_x <= XW'(IMG_W) &&
                   out_y >= YW'(1) && out_y <= YW'(IMG_H)));  // R2

  AST_RASTER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && have_prev && out_x != XW'(1)) |->
      (out_x == prev_x + XW'(1) && out_y == prev_y));  // R2

  AST_CORNER_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_x == XW'(1) && out_y == YW'(1)) |->
      (out_sum == SUM_W'(out_avg)));  // R5

  AST_CORNER_SQ: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_x == XW'(1) && out_y == YW'(1)) |->
      (out_avg_sq == SQ_W'(out_avg) * SQ_W'(out_avg)));  // R4

  AST_SQ_NOT_BELOW: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (SQ_W'(out_avg) * SQ_W'(out_avg) <= out_avg_sq));  // R4
endmodule

bind aii_engine aii_engine_chk #(
  .PIX_W(PIX_W), .IMG_W(IMG_W), .IMG_H(IMG_H)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pix_valid  (pix_valid),
  .out_valid  (out_valid),
  .out_x      (out_x),
  .out_y      (out_y),
  .out_avg    (out_avg),
  .out_avg_sq (out_avg_sq),
  .out_sum    (out_sum)
);

// File: tb/tb_aii_engine.sv
module tb_aii_engine;
  localparam int CLK_PERIOD = 10;
  localparam int PIX_W   = 8;
  localparam int IMG_W   = 4;
  localparam int IMG_H   = 3;
  localparam int XW      = $clog2(IMG_W + 1);
  localparam int YW      = $clog2(IMG_H + 1);
  localparam int SUM_W   = PIX_W + XW + YW;
  localparam int SQSUM_W = 2 * PIX_W + XW + YW;

  // vector: [9] start of frame, [8] one idle cycle before, [7:0] pixel
  localparam int NVEC = 20;
  localparam logic [9:0] VEC [NVEC] = '{
    10'h20A, 10'h014, 10'h01E, 10'h028,
    10'h000, 10'h0FF, 10'h007, 10'h064,
    10'h003, 10'h003, 10'h0C8, 10'h080,
    10'h132, 10'h03C, 10'h146, 10'h050, 10'h05A,
    10'h20B, 10'h016, 10'h021
  };

  logic               clk = 1'b0;
  logic               rst_n;
  logic               pix_valid;
  logic               pix_sof;
  logic [PIX_W-1:0]   pix_data;
  logic               out_valid;
  logic [XW-1:0]      out_x;
  logic [YW-1:0]      out_y;
  logic [PIX_W-1:0]   out_avg;
  logic [2*PIX_W-1:0] out_avg_sq;
  logic [SUM_W-1:0]   out_sum;
  logic [SQSUM_W-1:0] out_sum_sq;

  aii_engine #(.PIX_W(PIX_W), .IMG_W(IMG_W), .IMG_H(IMG_H)) dut (
    .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_sof(pix_sof),
    .pix_data(pix_data), .out_valid(out_valid), .out_x(out_x), .out_y(out_y),
    .out_avg(out_avg), .out_avg_sq(out_avg_sq), .out_sum(out_sum),
    .out_sum_sq(out_sum_sq)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  typedef struct {
    longint cyc; longint x; longint y; longint avg; longint avgsq;
    longint sum; longint sumsq; longint ii; longint iisq; bit sof;
  } exp_t;

  exp_t   q[$];
  int     checks = 0;
  int     fails  = 0;
  longint cyc    = 0;
  int     img [IMG_H][IMG_W];
  int     mcol = 0;
  int     mrow = 0;
  bit     done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, expv, cyc);
    end
  endtask

  // reference model built from the requirements
  task automatic send(input logic [7:0] p, input bit sof);
    exp_t e;
    longint ii = 0, iisq = 0, area;
    @(negedge clk);
    if (sof) begin mcol = 0; mrow = 0; end
    img[mrow][mcol] = int'(p);
    for (int r = 0; r <= mrow; r++)
      for (int c = 0; c <= mcol; c++) begin
        ii   += img[r][c];
        iisq += img[r][c] * img[r][c];
      end
    area    = longint'((mcol + 1) * (mrow + 1));
    e.cyc   = cyc + 3;
    e.x     = mcol + 1;
    e.y     = mrow + 1;
    e.ii    = ii;
    e.iisq  = iisq;
    e.avg   = ii / area;
    e.avgsq = iisq / area;
    e.sum   = e.avg * area;
    e.sumsq = e.avgsq * area;
    e.sof   = sof;
    q.push_back(e);
    if (mcol == IMG_W - 1) begin
      mcol = 0;
      mrow = (mrow == IMG_H - 1) ? 0 : mrow + 1;
    end else begin
      mcol++;
    end
    pix_valid = 1'b1;
    pix_sof   = sof;
    pix_data  = p;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      pix_valid = 1'b0;
      pix_sof   = 1'b0;
      pix_data  = '0;
    end
  endtask

  // result monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (rst_n === 1'b1 && out_valid === 1'b1) begin
      if (q.size() == 0) begin
        chk(1'b0, "R7 unexpected result", 1, 0);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(cyc == e.cyc, "R7 latency", cyc, e.cyc);
        chk(longint'(out_x) == e.x, "R2 x", longint'(out_x), e.x);
        chk(longint'(out_y) == e.y, "R2 y", longint'(out_y), e.y);
        chk(longint'(out_avg) == e.avg, "R3 mean", longint'(out_avg), e.avg);
        chk(longint'(out_avg_sq) == e.avgsq, "R4 mean of squares", longint'(out_avg_sq), e.avgsq);
        chk(longint'(out_sum) == e.sum, "R5 rescaled sum", longint'(out_sum), e.sum);
        chk(longint'(out_sum_sq) == e.sumsq, "R6 rescaled squares", longint'(out_sum_sq), e.sumsq);
        if (e.ii % (e.x * e.y) == 0)
          chk(longint'(out_sum) == e.ii, "R5 exact sum", longint'(out_sum), e.ii);
        if (e.iisq % (e.x * e.y) == 0)
          chk(longint'(out_sum_sq) == e.iisq, "R6 exact squares", longint'(out_sum_sq), e.iisq);
        if (e.sof)
          chk(out_x == XW'(1) && out_y == YW'(1), "R8 frame start", longint'(out_x), 1);
      end
    end
  end

  initial begin
    for (int i = 0; i < 5000; i++) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; pix_valid = 1'b0; pix_sof = 1'b0; pix_data = '0;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R1 valid low in reset", longint'(out_valid), 0);
    rst_n = 1'b1;
    idle(2);
    chk(out_valid == 1'b0, "R1 valid low after reset", longint'(out_valid), 0);

    // table walk: mixed frame, wrap with gaps, mid-row frame start
    for (int v = 0; v < NVEC; v++) begin
      if (VEC[v][8]) idle(1);
      send(VEC[v][7:0], VEC[v][9]);
    end
    idle(4);
    chk(q.size() == 0, "R7 all results seen", q.size(), 0);

    // full-scale constant frame: every sum exact (R5, R6)
    send(8'hFF, 1'b1);
    for (int i = 1; i < IMG_W * IMG_H; i++) send(8'hFF, 1'b0);
    // all-zero pixels following directly: wrap into a new frame (R2)
    for (int i = 0; i < IMG_W + 1; i++) send(8'h00, 1'b0);
    idle(4);
    chk(q.size() == 0, "R7 all results seen", q.size(), 0);

    // reset with results in flight (R1)
    send(8'h40, 1'b0);
    send(8'h41, 1'b0);
    @(negedge clk);
    rst_n = 1'b0; pix_valid = 1'b0; pix_sof = 1'b0;
    q.delete();
    mcol = 0; mrow = 0;
    idle(3);
    chk(out_valid == 1'b0, "R1 in-flight dropped", longint'(out_valid), 0);
    rst_n = 1'b1;
    idle(1);
    send(8'h09, 1'b0);
    send(8'h05, 1'b0);
    idle(5);
    chk(q.size() == 0, "R1 restart results seen", q.size(), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule